// File: doc/BRIEF.md
# Snooping Coherence Line-State Controller

This block holds the coherence state of every line in a small cache array and moves it in response to two streams of events: requests from the local processor and transactions observed on a shared snooping bus. A runtime select picks one of three invalidation protocols: three-state MSI, four-state MESI, or five-state MOESI. The same state machine serves all three. Tag lookup, data storage, victim choice and bus arbitration belong to neighbouring logic. The neighbours give this block line indices and a grant, and take back bus requests and data-movement strobes.

A processor access that needs the bus raises a read or read-exclusive request combinationally and holds it while the processor holds its request. The access commits on the cycle the arbiter grants it. In that cycle the wired shared line is sampled to choose between Exclusive and Shared. Snooped reads and read-exclusives can demote or invalidate lines. When they do, the block pulses strobes for a cache-to-cache data supply and for a memory write. The replacement logic can also evict a line, and evicting a dirty line pulses a writeback strobe. Any line's state can be read through a query index.

Top module: `snoop_line_ctrl`

## Requirements
- R1: After reset every line reads state 0 (Invalid) on `q_state`, and `flush`, `supply` and `wb` are low. The state codes are I=0, S=1, E=2, O=3, M=4.
- R2: `proto` selects the protocol with 0 = MSI, 1 = MESI, 2 = MOESI. Code 3 behaves as MSI. Under MSI, a read to an Invalid line always fills to S.
- R3: A processor read to an Invalid line raises `req_rd`. When it is granted, the line becomes E under MESI or MOESI if `bus_shared` is low in the grant cycle, and S otherwise. A read to a valid line raises no request and leaves the state unchanged. `req_rd` and `req_rdx` are never high together.
- R4: A processor write to an I, S or O line raises `req_rdx`, and the line becomes M when the write is granted. A write to an E or M line raises no request and sets M at once.
- R5: A processor access that needs the bus does not commit while `bus_grant` is low. `cpu_ack` stays low and the state stays unchanged. Accesses that need no bus are acknowledged without a grant.
- R6: A snooped read (`snp_excl`=0) to an M line pulses `supply` in the following cycle. Under MOESI the line becomes O and `flush` stays low. Under the other protocols the line becomes S and `flush` also pulses.
- R7: A snooped read to an O line keeps it in O and pulses `supply`. A snooped read to an E line moves it to S with no strobe. S and I lines are unchanged.
- R8: A snooped read-exclusive (`snp_excl`=1) sets the line to I. If the line was M or O, `flush` and `supply` pulse in the following cycle.
- R9: An eviction sets the line to I. If the line was M or O, `wb` pulses in the following cycle.
- R10: When events target the same index in one cycle, the snoop overrides the eviction, and both override the processor. The blocked processor access gets no `cpu_ack` and no bus request, and a dropped eviction gives no `wb`.
- R11: Each of `flush`, `supply` and `wb` is high for exactly the one cycle after its triggering event, unless a new event retriggers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| proto | input | 2 | Protocol select (0 MSI, 1 MESI, 2 MOESI) |
| cpu_valid | input | 1 | Processor access present |
| cpu_write | input | 1 | Access is a write |
| cpu_idx | input | IW | Line index of the access |
| bus_grant | input | 1 | Arbiter grants this block's request |
| bus_shared | input | 1 | Wired shared response, used in the grant cycle |
| snp_valid | input | 1 | Snooped transaction present |
| snp_excl | input | 1 | Snooped transaction is a read-exclusive |
| snp_idx | input | IW | Line index of the snoop |
| evict_valid | input | 1 | Replacement evicts a line |
| evict_idx | input | IW | Line index being evicted |
| q_idx | input | IW | Line index to report |
| req_rd | output | 1 | Bus read request |
| req_rdx | output | 1 | Bus read-exclusive / upgrade request |
| cpu_ack | output | 1 | Processor access commits this cycle |
| flush | output | 1 | Dirty data written to memory |
| supply | output | 1 | Dirty data driven to the requesting cache |
| wb | output | 1 | Writeback of an evicted dirty line |
| q_state | output | 3 | State of line `q_idx` |

## Verification
A line left in the wrong state shows up at the next event that targets that line. A wrongly clean line loses a `flush`, `supply` or `wb` pulse one cycle after a snoop or eviction. A wrongly valid line suppresses a bus request in the same cycle. The bench sweeps long event sequences over a few lines under all four `proto` codes. It compares requests and acknowledges within the cycle, strobes one cycle later, and every line's `q_state` through the query port. A corrupted line is therefore reported within a few dozen cycles, even if no later event touches it.

// File: rtl/snoop_line_ctrl.sv
module snoop_line_ctrl #(
  parameter int LINES = 8,
  localparam int IW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    proto,
  input  logic          cpu_valid,
  input  logic          cpu_write,
  input  logic [IW-1:0] cpu_idx,
  input  logic          bus_grant,
  input  logic          bus_shared,
  input  logic          snp_valid,
  input  logic          snp_excl,
  input  logic [IW-1:0] snp_idx,
  input  logic          evict_valid,
  input  logic [IW-1:0] evict_idx,
  input  logic [IW-1:0] q_idx,
  output logic          req_rd,
  output logic          req_rdx,
  output logic          cpu_ack,
  output logic          flush,
  output logic          supply,
  output logic          wb,
  output logic [2:0]    q_state
);
  localparam logic [2:0] ST_I = 3'd0, ST_S = 3'd1, ST_E = 3'd2, ST_O = 3'd3, ST_M = 3'd4;

  logic [2:0] st [LINES];

  wire moesi     = (proto == 2'd2);
  wire excl_ok   = (proto == 2'd1) || moesi;

  wire [2:0] cur = st[cpu_idx];
  wire [2:0] sn  = st[snp_idx];
  wire [2:0] ev  = st[evict_idx];

  wire blocked   = (snp_valid && snp_idx == cpu_idx) || (evict_valid && evict_idx == cpu_idx);
  wire need_rd   = !cpu_write && cur == ST_I;
  wire need_rdx  = cpu_write && (cur == ST_I || cur == ST_S || cur == ST_O);
  wire go        = cpu_valid && !blocked;

  assign req_rd  = go && need_rd;
  assign req_rdx = go && need_rdx;
  assign cpu_ack = go && ((need_rd || need_rdx) ? bus_grant : 1'b1);

  logic [2:0] cpu_nx;
  always_comb begin
    if (cpu_write)
      cpu_nx = ST_M;
    else if (cur == ST_I)
      cpu_nx = (excl_ok && !bus_shared) ? ST_E : ST_S;
    else
      cpu_nx = cur;
  end

  wire sn_dirty = (sn == ST_M) || (sn == ST_O);

  logic [2:0] snp_nx;
  logic       snp_fl, snp_sup;
  always_comb begin
    snp_nx  = sn;
    snp_fl  = 1'b0;
    snp_sup = 1'b0;
    if (snp_excl) begin
      snp_nx  = ST_I;
      snp_fl  = sn_dirty;
      snp_sup = sn_dirty;
    end else begin
      case (sn)
        ST_M: begin
          snp_nx  = moesi ? ST_O : ST_S;
          snp_sup = 1'b1;
          snp_fl  = !moesi;
        end
        ST_O: snp_sup = 1'b1;
        ST_E: snp_nx = ST_S;
        default: ;
      endcase
    end
  end

  wire evict_go = evict_valid && !(snp_valid && snp_idx == evict_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st[i] <= ST_I;
      flush  <= 1'b0;
      supply <= 1'b0;
      wb     <= 1'b0;
    end else begin
      flush  <= snp_valid && snp_fl;
      supply <= snp_valid && snp_sup;
      wb     <= evict_go && (ev == ST_M || ev == ST_O);
      if (cpu_ack)   st[cpu_idx]   <= cpu_nx;
      if (evict_go)  st[evict_idx] <= ST_I;
      if (snp_valid) st[snp_idx]   <= snp_nx;
    end
  end

  assign q_state = st[q_idx];
endmodule

module snoop_line_ctrl_chk #(
  parameter int LINES = 8,
  localparam int IW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    proto,
  input logic          cpu_valid,
  input logic          cpu_write,
  input logic [IW-1:0] cpu_idx,
  input logic          bus_grant,
  input logic          bus_shared,
  input logic          snp_valid,
  input logic          snp_excl,
  input logic [IW-1:0] snp_idx,
  input logic [IW-1:0] q_idx,
  input logic          req_rd,
  input logic          req_rdx,
  input logic          cpu_ack,
  input logic          flush,
  input logic          supply,
  input logic          wb,
  input logic [2:0]    q_state
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!flush && !supply && !wb));

  p_req_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_rd, req_rdx}));

  p_excl_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && req_rd && !bus_shared && proto == 2'd1 && q_idx == cpu_idx)
    |=> (q_idx != $past(cpu_idx) || q_state == 3'd2));

  p_write_mod_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && cpu_write && q_idx == cpu_idx)
    |=> (q_idx != $past(cpu_idx) || q_state == 3'd4));

  p_e_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_write && q_idx == cpu_idx && q_state == 3'd2) |-> !req_rdx);

  p_nogrant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_rd || req_rdx) && !bus_grant) |-> !cpu_ack);

  p_owned_supply_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !snp_excl && proto == 2'd2 && q_idx == snp_idx && q_state == 3'd4)
    |=> (supply && !flush));

  p_flush_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> supply);
endmodule

bind snoop_line_ctrl snoop_line_ctrl_chk #(.LINES(LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .proto(proto), .cpu_valid(cpu_valid),
  .cpu_write(cpu_write), .cpu_idx(cpu_idx), .bus_grant(bus_grant),
  .bus_shared(bus_shared), .snp_valid(snp_valid), .snp_excl(snp_excl),
  .snp_idx(snp_idx), .q_idx(q_idx), .req_rd(req_rd), .req_rdx(req_rdx),
  .cpu_ack(cpu_ack), .flush(flush), .supply(supply), .wb(wb), .q_state(q_state)
);

// File: tb/test_snoop_line_ctrl.sv
module test_snoop_line_ctrl;
  localparam int LINES = 8;
  localparam logic [2:0] I = 3'd0, S = 3'd1, E = 3'd2, O = 3'd3, M = 3'd4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] proto = 2'd0;
  logic cpu_valid = 1'b0, cpu_write = 1'b0, bus_grant = 1'b0, bus_shared = 1'b0;
  logic snp_valid = 1'b0, snp_excl = 1'b0, evict_valid = 1'b0;
  logic [2:0] cpu_idx = '0, snp_idx = '0, evict_idx = '0, q_idx = '0;
  logic req_rd, req_rdx, cpu_ack, flush, supply, wb;
  logic [2:0] q_state;

  int checks = 0, errors = 0;
  logic [2:0] m [LINES];
  logic [31:0] rng = 32'h1234_5678;

  always #5 clk = ~clk;

  snoop_line_ctrl #(.LINES(LINES)) i_snoop_line_ctrl (
    .clk(clk), .rst_n(rst_n), .proto(proto), .cpu_valid(cpu_valid),
    .cpu_write(cpu_write), .cpu_idx(cpu_idx), .bus_grant(bus_grant),
    .bus_shared(bus_shared), .snp_valid(snp_valid), .snp_excl(snp_excl),
    .snp_idx(snp_idx), .evict_valid(evict_valid), .evict_idx(evict_idx),
    .q_idx(q_idx), .req_rd(req_rd), .req_rdx(req_rdx), .cpu_ack(cpu_ack),
    .flush(flush), .supply(supply), .wb(wb), .q_state(q_state)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic clear_in();
    cpu_valid = 0; cpu_write = 0; bus_grant = 0; bus_shared = 0;
    snp_valid = 0; snp_excl = 0; evict_valid = 0;
  endtask

  task automatic sweep(string req);
    for (int i = 0; i < LINES; i++) begin
      q_idx = 3'(i);
      #1 check(req, q_state, m[i]);
    end
  endtask

  // kind: 0 read, 1 write, 2 snoop read, 3 snoop read-exclusive, 4 evict
  task automatic do_op(int kind, int idx, bit g, bit sh);
    logic [2:0] s, ns;
    bit e_rd, e_rdx, e_ack, e_fl, e_sup, e_wb, need;
    s = m[idx]; ns = s;
    e_rd = 0; e_rdx = 0; e_ack = 0; e_fl = 0; e_sup = 0; e_wb = 0;
    case (kind)
      0, 1: begin
        e_rd  = (kind == 0) && s == I;
        e_rdx = (kind == 1) && (s == I || s == S || s == O);
        need  = e_rd || e_rdx;
        e_ack = !need || g;
        if (e_ack) begin
          if (kind == 1) ns = M;
          else if (s == I) ns = ((proto == 1 || proto == 2) && !sh) ? E : S;
        end
      end
      2: begin
        if (s == M) begin ns = (proto == 2) ? O : S; e_sup = 1; e_fl = (proto != 2); end
        else if (s == O) e_sup = 1;
        else if (s == E) ns = S;
      end
      3: begin ns = I; e_fl = (s == M || s == O); e_sup = e_fl; end
      default: begin ns = I; e_wb = (s == M || s == O); end
    endcase
    q_idx = 3'(idx);
    case (kind)
      0, 1: begin cpu_valid = 1; cpu_write = (kind == 1); cpu_idx = 3'(idx);
                  bus_grant = g; bus_shared = sh; end
      2, 3: begin snp_valid = 1; snp_excl = (kind == 3); snp_idx = 3'(idx); end
      default: begin evict_valid = 1; evict_idx = 3'(idx); end
    endcase
    #1;
    check("R3 req_rd", req_rd, e_rd);
    check("R4 req_rdx", req_rdx, e_rdx);
    check("R5 cpu_ack", cpu_ack, e_ack);
    @(negedge clk);
    clear_in();
    check("R6 R8 flush", flush, e_fl);
    check("R7 R8 supply", supply, e_sup);
    check("R9 wb", wb, e_wb);
    #1 check(kind < 2 ? "R2 R3 R4 R5 state" : (kind == 4 ? "R9 state" : "R6 R7 R8 state"), q_state, ns);
    m[idx] = ns;
  endtask

  initial begin
    for (int i = 0; i < LINES; i++) m[i] = I;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 flush", flush, 0);
    check("R1 supply", supply, 0);
    check("R1 wb", wb, 0);
    sweep("R1 reset state");

    for (int p = 0; p < 4; p++) begin
      proto = 2'(p);
      for (int n = 0; n < 500; n++) begin
        rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
        do_op(int'(rng % 5), int'((rng >> 4) & 3), ((rng >> 8) & 3) != 0, rng[10]);
        if (n % 32 == 31) sweep("R11 all lines");
      end
      sweep("R2 per-protocol lines");
    end

    // R10: same-index collisions
    proto = 2'd2;
    do_op(1, 5, 1, 0);
    cpu_valid = 1; cpu_write = 1; cpu_idx = 3'd5; bus_grant = 1;
    snp_valid = 1; snp_excl = 0; snp_idx = 3'd5; q_idx = 3'd5;
    #1 check("R10 blocked ack", cpu_ack, 0);
    check("R10 blocked req", req_rdx, 0);
    @(negedge clk); clear_in();
    check("R10 snoop supply", supply, 1);
    check("R10 snoop flush", flush, 0);
    #1 check("R10 snoop wins", q_state, O);
    @(negedge clk);
    check("R11 supply drops", supply, 0);
    evict_valid = 1; evict_idx = 3'd5; snp_valid = 1; snp_excl = 1; snp_idx = 3'd5;
    cpu_valid = 1; cpu_write = 0; cpu_idx = 3'd5;
    #1 check("R10 evict blocks cpu", cpu_ack, 0);
    @(negedge clk); clear_in();
    check("R10 dropped evict wb", wb, 0);
    check("R10 rdx flush", flush, 1);
    #1 check("R10 state", q_state, I);
    m[5] = I;
    @(negedge clk);
    check("R11 flush drops", flush, 0);
    sweep("R10 final lines");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule